// File: doc/BRIEF.md
# Page Program Collection Buffer

This block gathers the data bytes of a serial flash page-program command and commits them to the flash array. A command opens with a start pulse carrying a 24-bit address. Bits 19:8 select the page and bits 7:0 give the first byte offset. After that, received bytes arrive one per strobe. Each byte lands in a 256-entry page buffer at the current offset. A per-byte valid flag is set for that slot, and the offset moves on, wrapping inside the same page.

When chip select is released, the surrounding logic reports whether the release fell exactly on a byte boundary, and it also supplies a write-permission level. A commit needs all of the following:
- a byte-aligned release,
- permission set,
- at least one valid byte.

On a commit, the block walks the whole page through a read-modify-write array port. It writes only the valid offsets, with the new value being the old byte ANDed with the buffered byte. It then holds a write-in-progress flag for a parameterised program time. At the first busy cycle it pulses a request to clear the write-enable latch. While busy, all command, byte and release inputs are ignored.

Top module: `pp_page_buffer`

## Requirements
- R1: Each accepted byte goes to the current offset, and the offset then advances by one modulo 256. Past offset 255 it wraps to offset 0 of the same page, so the page address bits 19:8 never change within a command.
- R2: When more than 256 bytes arrive in one command, a later byte overwrites the earlier byte at the same offset. Only the last 256 bytes received are programmed.
- R3: Offsets of the page that received no byte in the command are never written, and array bytes outside the page are untouched.
- R4: Programming only clears bits: each written array byte becomes its previous value ANDed with the buffered byte.
- R5: A release with the byte-boundary flag low discards the command. Nothing is written and the busy flag stays low.
- R6: After a commit, the busy flag is high from the cycle following the release edge for exactly 256 + PROG_CYCLES cycles. Array writes occur only while busy.
- R7: The write-enable clear output pulses for exactly one cycle per commit, in the first busy cycle.
- R8: Start address bits 23:20 have no effect: the array address is start address bits 19:8 followed by the offset.
- R9: A release with permission low, or with no data byte received, writes nothing and leaves the busy flag low.
- R10: A new command start clears all valid flags and reloads the offset. Bytes from an earlier discarded command are never programmed.
- R11: While busy, command starts, byte strobes and releases are ignored. They change neither the buffered data nor the valid flags, nor do they start a new commit.
- R12: After reset the busy flag, array write enable and write-enable clear output are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_start_i | input | 1 | Pulse: new program command begins |
| start_addr_i | input | 24 | Start address, sampled with cmd_start_i |
| byte_vld_i | input | 1 | Strobe: a received data byte is present |
| byte_i | input | 8 | Received data byte |
| cs_release_i | input | 1 | Pulse: chip select released |
| byte_aligned_i | input | 1 | Release fell on a byte boundary |
| wr_perm_i | input | 1 | Write permission level |
| arr_addr_o | output | 20 | Array byte address |
| arr_rdata_i | input | 8 | Array read data for arr_addr_o (combinational) |
| arr_we_o | output | 1 | Array write enable |
| arr_wdata_o | output | 8 | Array write data |
| busy_o | output | 1 | Write in progress |
| wel_clr_o | output | 1 | Pulse: clear the write-enable latch |

## Verification
Commands are tried with start offsets near the page end, so that short runs cross the wrap point. Runs longer than a page show whether later bytes replace earlier ones. Short runs show whether untouched offsets stay as they were. The array starts with random content, which separates AND-style programming from a plain overwrite.

Each qualifying condition is exercised alone, one per command:
- a misaligned release,
- missing permission,
- zero bytes,
- a discarded command followed by a short one.

Each of these must leave the array and the busy flag alone. Random commands add random upper address bits and junk traffic while busy, which exposes any leak from the upper address bits or from the busy window.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic {
    WK_IDLE,
    WK_RUN
  } walk_st_e;
endpackage

// File: rtl/pp_collect.sv
module pp_collect #(
  parameter int PAGE_W = 8,
  parameter int ARR_AW = 20,
  localparam int PAGE_B = 1 << PAGE_W,
  localparam int PG_AW  = ARR_AW - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              cmd_start_i,
  input  logic [ARR_AW-1:0] start_addr_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              cs_release_i,
  input  logic              byte_aligned_i,
  input  logic              wr_perm_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic              commit_o,
  output logic [PG_AW-1:0]  page_o,
  output logic [7:0]        rd_byte_o,
  output logic              rd_vld_o
);
  logic              armed_q;
  logic [PAGE_W-1:0] ptr_q;
  logic [PAGE_B-1:0] mask_q;
  logic [PG_AW-1:0]  page_q;
  logic [7:0]        data_q [PAGE_B];
  logic              open_ok;
  logic              take_byte;

  assign open_ok   = !busy_i;
  assign take_byte = open_ok && armed_q && byte_vld_i && !cs_release_i && !cmd_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      ptr_q   <= '0;
      mask_q  <= '0;
      page_q  <= '0;
    end else if (open_ok) begin
      if (cs_release_i) begin
        armed_q <= 1'b0;
      end else if (cmd_start_i) begin
        armed_q <= 1'b1;
        ptr_q   <= start_addr_i[PAGE_W-1:0];
        page_q  <= start_addr_i[ARR_AW-1:PAGE_W];
        mask_q  <= '0;
      end else if (take_byte) begin
        mask_q[ptr_q] <= 1'b1;
        ptr_q         <= ptr_q + 1'b1;  // wraps inside the page
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (take_byte) data_q[ptr_q] <= byte_i;
  end

  assign commit_o  = open_ok && armed_q && cs_release_i && byte_aligned_i && wr_perm_i && (|mask_q);
  assign page_o    = page_q;
  assign rd_byte_o = data_q[rd_idx_i];
  assign rd_vld_o  = mask_q[rd_idx_i];

  // R11
  mask_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(mask_q));
  // R10
  mask_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_start_i && !busy_i && !cs_release_i) |=> (mask_q == '0));
endmodule

// File: rtl/pp_walker.sv
module pp_walker
  import pp_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int PG_AW  = 12,
  localparam int ARR_AW = PG_AW + PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [PG_AW-1:0]  page_i,
  input  logic [7:0]        rd_byte_i,
  input  logic              rd_vld_i,
  input  logic [7:0]        arr_rdata_i,
  output logic [PAGE_W-1:0] rd_idx_o,
  output logic [ARR_AW-1:0] arr_addr_o,
  output logic              arr_we_o,
  output logic [7:0]        arr_wdata_o,
  output logic              busy_o,
  output logic              first_o,
  output logic              last_o
);
  walk_st_e          st_q;
  logic [PAGE_W-1:0] idx_q;
  logic              run;

  assign run = (st_q == WK_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= WK_IDLE;
      idx_q <= '0;
    end else begin
      unique case (st_q)
        WK_IDLE: if (commit_i) begin
          st_q  <= WK_RUN;
          idx_q <= '0;
        end
        WK_RUN: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == '1) st_q <= WK_IDLE;
        end
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  assign rd_idx_o    = idx_q;
  assign arr_addr_o  = {page_i, idx_q};
  assign arr_we_o    = run && rd_vld_i;
  assign arr_wdata_o = arr_rdata_i & rd_byte_i;  // program clears bits only
  assign busy_o      = run;
  assign first_o     = run && (idx_q == '0);
  assign last_o      = run && (idx_q == '1);

  // R1
  page_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !last_o) |=> $stable(page_i));
endmodule

// File: rtl/pp_timer.sv
module pp_timer #(
  parameter int PROG_CYCLES = 64,
  localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CNT_W'(PROG_CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R6
  timer_idle_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/pp_page_buffer.sv
module pp_page_buffer #(
  parameter int ADDR_W      = 24,
  parameter int ARR_AW      = 20,
  parameter int PAGE_W      = 8,
  parameter int PROG_CYCLES = 64,
  localparam int PG_AW = ARR_AW - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              cs_release_i,
  input  logic              byte_aligned_i,
  input  logic              wr_perm_i,
  output logic [ARR_AW-1:0] arr_addr_o,
  input  logic [7:0]        arr_rdata_i,
  output logic              arr_we_o,
  output logic [7:0]        arr_wdata_o,
  output logic              busy_o,
  output logic              wel_clr_o
);
  logic              commit;
  logic [PG_AW-1:0]  page;
  logic [7:0]        rd_byte;
  logic              rd_vld;
  logic [PAGE_W-1:0] rd_idx;
  logic              walk_busy, walk_first, walk_last, tmr_busy;
  logic              unused_hi;

  assign unused_hi = ^start_addr_i[ADDR_W-1:ARR_AW];

  pp_collect #(.PAGE_W(PAGE_W), .ARR_AW(ARR_AW)) u_collect (
    .clk_i, .rst_ni,
    .busy_i        (busy_o),
    .cmd_start_i,
    .start_addr_i  (start_addr_i[ARR_AW-1:0]),
    .byte_vld_i, .byte_i, .cs_release_i, .byte_aligned_i, .wr_perm_i,
    .rd_idx_i      (rd_idx),
    .commit_o      (commit),
    .page_o        (page),
    .rd_byte_o     (rd_byte),
    .rd_vld_o      (rd_vld)
  );

  pp_walker #(.PAGE_W(PAGE_W), .PG_AW(PG_AW)) u_walker (
    .clk_i, .rst_ni,
    .commit_i    (commit),
    .page_i      (page),
    .rd_byte_i   (rd_byte),
    .rd_vld_i    (rd_vld),
    .arr_rdata_i,
    .rd_idx_o    (rd_idx),
    .arr_addr_o, .arr_we_o, .arr_wdata_o,
    .busy_o      (walk_busy),
    .first_o     (walk_first),
    .last_o      (walk_last)
  );

  pp_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk_i, .rst_ni,
    .start_i (walk_last),
    .busy_o  (tmr_busy)
  );

  assign busy_o    = walk_busy | tmr_busy;
  assign wel_clr_o = walk_first;

  // R6
  we_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o);
  // R7
  wel_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> wel_clr_o);
  // R7
  wel_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |=> !wel_clr_o);
  // R5
  misaligned_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cs_release_i && !byte_aligned_i) |=> !busy_o);
  // R9
  no_perm_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cs_release_i && !wr_perm_i) |=> !busy_o);
endmodule

// File: tb/pp_page_buffer_bench.sv
module pp_page_buffer_bench;
  localparam int PROG = 64;
  localparam int BUSY_LEN = 256 + PROG;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [23:0] start_addr = '0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_d = '0;
  logic        cs_release = 1'b0;
  logic        byte_aligned = 1'b0;
  logic        wr_perm = 1'b0;
  logic [19:0] arr_addr;
  logic [7:0]  arr_rdata;
  logic        arr_we;
  logic [7:0]  arr_wdata;
  logic        busy;
  logic        wel_clr;

  int n_chk = 0, n_bad = 0, cyc = 0, wel_cnt = 0;
  logic [7:0]  mem [1024];
  logic [7:0]  exp_mem [1024];
  logic [7:0]  m_buf [256];
  logic        m_msk [256];
  logic [11:0] exp_page = '0;

  always #10 clk = ~clk;

  pp_page_buffer #(.PROG_CYCLES(PROG)) u_pp_page_buffer (
    .clk_i(clk), .rst_ni(rst_n), .cmd_start_i(cmd_start), .start_addr_i(start_addr),
    .byte_vld_i(byte_vld), .byte_i(byte_d), .cs_release_i(cs_release),
    .byte_aligned_i(byte_aligned), .wr_perm_i(wr_perm), .arr_addr_o(arr_addr),
    .arr_rdata_i(arr_rdata), .arr_we_o(arr_we), .arr_wdata_o(arr_wdata),
    .busy_o(busy), .wel_clr_o(wel_clr)
  );

  assign arr_rdata = mem[arr_addr[9:0]];
  always @(posedge clk) if (arr_we) mem[arr_addr[9:0]] <= arr_wdata;
  always @(posedge clk) if (rst_n && wel_clr) wel_cnt <= wel_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R8: array page must equal start address bits 19:8
  always @(negedge clk) if (rst_n && arr_we)
    chk(arr_addr[19:8] == exp_page, "R8 page addr", int'(arr_addr[19:8]), int'(exp_page));

  function automatic int mem_diffs();
    int d = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) d++;
    return d;
  endfunction

  task automatic run_cmd(input logic [23:0] addr, input int n, input bit perm,
                         input bit aligned, input bit junk, input string req);
    logic [7:0] ptr;
    bit ok_commit;
    int w0, len;
    @(negedge clk);
    cmd_start = 1'b1; start_addr = addr;
    @(negedge clk);
    cmd_start = 1'b0;
    exp_page = addr[19:8];
    for (int i = 0; i < 256; i++) m_msk[i] = 1'b0;
    ptr = addr[7:0];
    for (int i = 0; i < n; i++) begin
      byte_vld = 1'b1; byte_d = 8'($urandom);
      m_buf[ptr] = byte_d; m_msk[ptr] = 1'b1; ptr = ptr + 8'd1;
      @(negedge clk);
    end
    byte_vld = 1'b0;
    wr_perm = perm; cs_release = 1'b1; byte_aligned = aligned;
    w0 = wel_cnt;
    @(negedge clk);
    cs_release = 1'b0;
    ok_commit = perm && aligned && (n > 0);
    chk(busy == ok_commit, {req, " busy after release (R5/R9)"}, int'(busy), int'(ok_commit));
    if (ok_commit) begin
      for (int o = 0; o < 256; o++)
        if (m_msk[o]) exp_mem[{addr[9:8], 8'(o)}] = exp_mem[{addr[9:8], 8'(o)}] & m_buf[o];
      len = 0;
      while (busy && len < 2000) begin
        len++;
        if (junk) begin  // R11 traffic while busy
          byte_vld = 1'b1; byte_d = 8'($urandom); cmd_start = (len % 37 == 0);
          start_addr = 24'($urandom); cs_release = (len % 53 == 0); byte_aligned = 1'b1;
        end
        @(negedge clk);
      end
      byte_vld = 1'b0; cmd_start = 1'b0; cs_release = 1'b0;
      chk(len == BUSY_LEN, "R6 busy length", len, BUSY_LEN);
      chk(wel_cnt - w0 == 1, "R7 wel clear pulses", wel_cnt - w0, 1);
      repeat (2) @(negedge clk);
      chk(!busy, "R11 no restart from junk", int'(busy), 0);
    end else begin
      repeat (4) @(negedge clk);
      chk(!busy && wel_cnt == w0, {req, " stays idle"}, int'(busy), 0);
    end
    chk(mem_diffs() == 0, {req, " array content"}, mem_diffs(), 0);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'($urandom);
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R12
    chk(!busy && !arr_we && !wel_clr, "R12 reset state", int'({busy, arr_we, wel_clr}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !wel_clr, "R12 after release", int'({busy, wel_clr}), 0);

    run_cmd(24'h0001FA, 10, 1, 1, 0, "R1 wrap at page end");
    run_cmd(24'h000210, 300, 1, 1, 0, "R2 last 256 kept");
    run_cmd(24'h000380, 3, 1, 1, 0, "R3 short run, R4 and-merge");
    run_cmd(24'h000100, 40, 1, 0, 0, "R5 misaligned");
    run_cmd(24'h000200, 40, 0, 1, 0, "R9 no permission");
    run_cmd(24'h000300, 0, 1, 1, 0, "R9 zero bytes");
    run_cmd(24'h000040, 30, 1, 0, 0, "R10 discarded first");
    run_cmd(24'h000050, 1, 1, 1, 0, "R10 new command clears");
    run_cmd(24'hF5A2F0, 20, 1, 1, 1, "R8 upper bits, R11 junk");
    for (int k = 0; k < 16; k++) begin
      automatic int n = ($urandom % 4 == 0) ? 256 + int'($urandom % 60) : 1 + int'($urandom % 200);
      run_cmd(24'($urandom), n, ($urandom % 6) != 0, ($urandom % 6) != 0, $urandom % 2,
              "R1/R2/R3/R4 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule